// File: doc/BRIEF.md
# Split-Write 64-Bit Address Register

This block holds one 64-bit address that software programs over a register bus whose data path is only 32 bits wide. Software sets the value in one of two ways. It can issue a single 64-bit access, or it can issue two dword accesses, the lower dword first and the upper dword second. Downstream logic sees only a committed copy of the address. That copy never shows a half-updated value, and every change to it comes with a one-cycle update strobe.

The parameter `WIDE_ADDR` picks the flavour. When it is 1, the block is 64-bit capable: a lower-dword write is held in a shadow register, and the upper-dword write publishes both halves together. When it is 0, the block addresses only 32 bits: a lower-dword write publishes straight away, the upper dword stays zero, and upper-dword writes are dropped.

Top module: `split_addr_reg`

## Requirements
- R1: After reset, `addr_q` is zero, `addr_upd` is low and no lower dword is pending. In 64-bit-capable mode, an upper-dword write that comes first uses a lower half of zero.
- R2: In 64-bit-capable mode, a write with `wr_wide`=1 at offset 0 loads all 64 bits of `wr_data` into `addr_q` on the next edge, with one `addr_upd` pulse, and clears any pending lower dword.
- R3: In 64-bit-capable mode, a dword write (`wr_wide`=0) at offset 0 leaves `addr_q` unchanged and raises no `addr_upd`. It stores `wr_data[31:0]` as the pending lower dword.
- R4: In 64-bit-capable mode, a dword write at offset 4 while a lower dword is pending loads {`wr_data[31:0]`, pending lower} into `addr_q` in one cycle, with one `addr_upd` pulse, and clears the pending state.
- R5: In 64-bit-capable mode, a second lower-dword write that comes before any upper-dword write replaces the pending value.
- R6: In 64-bit-capable mode, a dword write at offset 4 with nothing pending keeps the committed lower 32 bits and replaces the upper 32, with one `addr_upd` pulse.
- R7: In 32-bit-only mode, a dword write at offset 0 loads {32'h0, `wr_data[31:0]`} on the next edge, with one `addr_upd` pulse.
- R8: In 32-bit-only mode, dword writes at offset 4 leave `addr_q` unchanged and raise no `addr_upd`.
- R9: In 32-bit-only mode, `addr_q[63:32]` is always zero. A wide write at offset 0 commits only `wr_data[31:0]`, with one `addr_upd` pulse.
- R10: A write to any offset other than 0 or 4 has no effect. A wide write at offset 4 has no effect either.
- R11: `addr_upd` is high only in the cycle after a committing write. It is low after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_ofs | input | OFS_W | Byte offset: 0 is the lower dword, 4 is the upper dword |
| wr_data | input | 64 | Write data; dword accesses use bits 31:0 |
| wr_wide | input | 1 | 1 marks a 64-bit access |
| addr_q | output | 64 | Committed address |
| addr_upd | output | 1 | One-cycle pulse when `addr_q` is written |

## Verification
Every result is a registered output. A write presented before a rising edge shows up on `addr_q` and `addr_upd` right after that edge, and the strobe is low again one edge later. The bench drives inputs on the falling edge and compares both outputs on the next falling edge, so each check falls exactly one edge after its stimulus. Two instances, one in each mode, receive the same stimulus and are compared against separate bench models. Random traffic is mixed with directed sequences that cover pending replacement, an upper-dword write with nothing pending, and stray offsets.

// File: rtl/split_addr_reg.sv
module split_addr_reg #(
  parameter bit WIDE_ADDR = 1'b1,
  parameter int AW        = 64,
  parameter int OFS_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [AW-1:0]    wr_data,
  input  logic             wr_wide,
  output logic [AW-1:0]    addr_q,
  output logic             addr_upd
);
  localparam int HW = AW / 2;
  localparam logic [OFS_W-1:0] LO_OFS = '0;
  localparam logic [OFS_W-1:0] HI_OFS = OFS_W'(4);

  logic          pend;
  logic [HW-1:0] pend_lo;

  wire lo_hit = wr_en && (wr_ofs == LO_OFS);
  wire hi_hit = wr_en && (wr_ofs == HI_OFS) && !wr_wide;
  wire [HW-1:0] dlo = wr_data[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      addr_upd <= 1'b0;
      pend     <= 1'b0;
      pend_lo  <= '0;
    end else begin
      addr_upd <= 1'b0;
      if (lo_hit && wr_wide) begin
        addr_q   <= WIDE_ADDR ? wr_data : {{HW{1'b0}}, dlo};
        addr_upd <= 1'b1;
        pend     <= 1'b0;
      end else if (lo_hit) begin
        if (WIDE_ADDR) begin
          pend_lo <= dlo;
          pend    <= 1'b1;
        end else begin
          addr_q   <= {{HW{1'b0}}, dlo};
          addr_upd <= 1'b1;
        end
      end else if (hi_hit && WIDE_ADDR) begin
        addr_q   <= {dlo, pend ? pend_lo : addr_q[HW-1:0]};
        addr_upd <= 1'b1;
        pend     <= 1'b0;
      end
    end
  end

  AST_LO_NO_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_ADDR && lo_hit && !wr_wide) |=> ($stable(addr_q) && !addr_upd)); // R3
  AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_ADDR && hi_hit) |=> (addr_upd && addr_q[AW-1:HW] == $past(wr_data[HW-1:0]))); // R4
  AST_HI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!WIDE_ADDR && hi_hit) |=> ($stable(addr_q) && !addr_upd)); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !WIDE_ADDR |-> (addr_q[AW-1:HW] == '0)); // R9
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!addr_upd && $stable(addr_q))); // R11
endmodule

// File: tb/split_addr_reg_tb.sv
module split_addr_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_ofs = '0;
  logic [63:0] wr_data = '0;
  logic        wr_wide = 1'b0;
  logic [63:0] q_w, q_n;
  logic        u_w, u_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [63:0] ew_addr, en_addr;
  logic        ew_pend;
  logic [31:0] ew_plo;
  logic        ew_upd, en_upd;
  string       tag_w, tag_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_addr_reg #(.WIDE_ADDR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .wr_wide(wr_wide), .addr_q(q_w), .addr_upd(u_w));

  split_addr_reg #(.WIDE_ADDR(1'b0)) u_dut_n32 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .wr_wide(wr_wide), .addr_q(q_n), .addr_upd(u_n));

  function automatic bit is_lo(logic en, logic [3:0] o);
    return en && o == 4'd0;
  endfunction

  function automatic bit is_hi(logic en, logic [3:0] o, logic w);
    return en && o == 4'd4 && !w;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic en, logic [3:0] o, logic [63:0] d, logic w);
    wr_en = en; wr_ofs = o; wr_data = d; wr_wide = w;
    ew_upd = 1'b0; en_upd = 1'b0;
    tag_w = "R10"; tag_n = "R10";
    if (!en) begin
      tag_w = "R11"; tag_n = "R11";
    end else if (is_lo(en, o) && w) begin
      ew_addr = d; ew_pend = 1'b0; ew_upd = 1'b1; tag_w = "R2";
      en_addr = {32'h0, d[31:0]}; en_upd = 1'b1; tag_n = "R9";
    end else if (is_lo(en, o)) begin
      tag_w = ew_pend ? "R5" : "R3";
      ew_plo = d[31:0]; ew_pend = 1'b1;
      en_addr = {32'h0, d[31:0]}; en_upd = 1'b1; tag_n = "R7";
    end else if (is_hi(en, o, w)) begin
      tag_w = ew_pend ? "R4" : "R6";
      ew_addr = {d[31:0], ew_pend ? ew_plo : ew_addr[31:0]};
      ew_pend = 1'b0; ew_upd = 1'b1;
      tag_n = "R8";
    end
    @(negedge clk);
    check(tag_w, "wide addr_q", q_w, ew_addr);
    check(tag_w, "wide addr_upd", {63'h0, u_w}, {63'h0, ew_upd});
    check(tag_n, "n32 addr_q", q_n, en_addr);
    check(tag_n, "n32 addr_upd", {63'h0, u_n}, {63'h0, en_upd});
  endtask

  initial begin
    ew_addr = '0; en_addr = '0; ew_pend = 1'b0; ew_plo = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "wide addr_q", q_w, 64'h0);
    check("R1", "wide addr_upd", {63'h0, u_w}, 64'h0);
    check("R1", "n32 addr_q", q_n, 64'h0);
    rst_n = 1'b1;
    // R1/R6: upper write right after reset pairs with low 0
    step(1, 4'd4, 64'h0000_0000_dead_beef, 0);
    // R3, R5, R4
    step(1, 4'd0, 64'h0000_0000_1111_1111, 0);
    step(0, 4'd0, 64'h0, 0);
    step(1, 4'd0, 64'h0000_0000_2222_2222, 0);
    step(1, 4'd4, 64'h0000_0000_3333_3333, 0);
    // R2 and R9
    step(1, 4'd0, 64'hcafe_f00d_0123_4567, 1);
    // R10: stray offsets and wide at upper offset
    step(1, 4'd8, 64'hffff_ffff_ffff_ffff, 0);
    step(1, 4'd4, 64'haaaa_aaaa_bbbb_bbbb, 1);
    step(1, 4'd2, 64'h5555_5555_5555_5555, 1);
    // R6 with nonzero committed low
    step(1, 4'd4, 64'h0000_0000_7777_7777, 0);
    // R2 clears pending: pending low then wide then upper
    step(1, 4'd0, 64'h0000_0000_9999_9999, 0);
    step(1, 4'd0, 64'h1234_5678_abcd_ef01, 1);
    step(1, 4'd4, 64'h0000_0000_4444_4444, 0);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] o;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 5));
      o = (pick < 2) ? 4'd0 : (pick < 4) ? 4'd4 : 4'($urandom);
      step($urandom_range(0, 4) != 0, o, {$urandom, $urandom}, $urandom_range(0, 3) == 0);
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule